// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a page directory entry and then a page table entry from memory. The directory base is supplied by a control-register style input. The walker also checks access rights for the request (read or write, supervisor or user, with an optional write-protect rule). It reports the physical address, the effective rights and, on a violation, a fault flag with a three-bit error code.

While it walks, the block keeps the accessed and dirty status bits in memory up to date. It writes back an entry only when one of those bits actually changes. A small direct-mapped translation cache holds merged entries, so a repeated page costs no memory traffic. A global flush input empties the cache.

When paging is off, the address passes through unchanged. The block runs one lookup at a time and has one memory access outstanding at most. It pulses `done` for one cycle with the result.

Top module: `pt_walker`

## Requirements
- R1: After reset `done` and `mem_req` are low and `req_ready` is high.
- R2: With `pg_en` low at acceptance, the result is `res_phys` equal to `req_lin`, no fault, code 0, both rights bits 1, and no memory access. `done` rises in the cycle after acceptance.
- R3: The directory entry is read at `dir_base` plus 4 times linear bits 31:22. The table entry is read at the directory entry's bits 31:12 shifted left by 12, plus 4 times linear bits 21:12.
- R4: A directory entry with bit 0 (present) clear ends the walk with a fault after exactly one memory access.
- R5: A present directory entry with bit 5 (accessed) clear is written back, to the same address and with bit 5 set, before the table entry is read.
- R6: A table entry with bit 0 clear gives a fault and no write-back.
- R7: A present table entry gets bit 5 set, and bit 6 (dirty) set on a write lookup. It is written back once, to its own address, exactly when this changes its value.
- R8: Without a fault, `res_phys` is the table entry's bits 31:12 followed by linear bits 11:0. The effective writable and user rights are the AND of bit 1 of both entries and the AND of bit 2 of both entries.
- R9: A fault is raised for a non-present entry, for a user access to a page whose effective bit 2 is 0, and for a write to a page whose effective bit 1 is 0 while `wp_en` is high. `fault_code` is {user, write, present}; it is 0 without a fault. On a fault `res_phys` and both rights bits are 0.
- R10: The cache is indexed by the low CACHE_IDX_W bits of linear bits 31:12 and tagged with the rest. A hit gives the result without any memory access and does not change memory. A completed walk with a present table entry fills the indexed slot with the merged entry, even if it faults on rights.
- R11: A `flush` pulse invalidates every cache slot, so the next lookup of any page walks memory again.
- R12: `mem_req` is held with stable address, write flag and data until `mem_ack`. `req_ready` is low while a walk is in progress.
- R13: `done` is high for exactly one cycle per lookup, and `req_ready` returns in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Current privilege is non-zero |
| pg_en | input | 1 | Paging enabled |
| wp_en | input | 1 | Write-protect enforced |
| dir_base | input | 32 | Page directory base address |
| flush | input | 1 | Invalidate the whole cache |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done | output | 1 | Result valid pulse |
| res_phys | output | 32 | Physical address |
| res_writable | output | 1 | Effective writable right |
| res_user | output | 1 | Effective user right |
| fault | output | 1 | Access faulted |
| fault_code | output | 3 | {user, write, present} |

## Verification
A stale cache slot shows up on the same lookup: memory traffic is missing and the frame or rights are wrong, so a directed flush-then-repeat sequence and random aliasing pages expose it. A wrong write-back decision shows up as a mismatched write count or as a wrong memory word right after `done`. A skipped directory write-back changes the position of the table read in the access log. A walk state that is off by one shows up at once as a wrong memory address or as a missing or doubled `done` pulse.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W  = 32;
    localparam int OFS_W = 12;
    localparam int DIR_W = 10;
    localparam int TBL_W = 10;
    localparam int VPN_W = VA_W - OFS_W;
    localparam int ENT_B = 4;

    localparam int B_PRES = 0;
    localparam int B_WR   = 1;
    localparam int B_USR  = 2;
    localparam int B_ACC  = 5;
    localparam int B_DRT  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_WB,
        ST_TBL_RD,
        ST_TBL_WB,
        ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic            fault;
        logic [2:0]      code;
        logic [VA_W-1:0] phys;
        logic            wr_ok;
        logic            usr_ok;
    } walk_res_t;
endpackage

// File: rtl/ptw_tcache.sv
module ptw_tcache
    import ptw_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output logic [VA_W-1:0]  hit_ent,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [VA_W-1:0]  fill_ent
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = VPN_W - IDX_W;

    logic [DEPTH-1:0] vld_d, vld_q;
    logic [TAG_W-1:0] tag_d [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [VA_W-1:0]  ent_d [DEPTH];
    logic [VA_W-1:0]  ent_q [DEPTH];

    logic [IDX_W-1:0] look_idx, fill_idx;
    logic [TAG_W-1:0] look_tag, fill_tag;

    assign look_idx = look_vpn[IDX_W-1:0];
    assign look_tag = look_vpn[VPN_W-1:IDX_W];
    assign fill_idx = fill_vpn[IDX_W-1:0];
    assign fill_tag = fill_vpn[VPN_W-1:IDX_W];

    always_comb begin
        vld_d = vld_q;
        tag_d = tag_q;
        ent_d = ent_q;
        if (fill_en) begin
            vld_d[fill_idx] = 1'b1;
            tag_d[fill_idx] = fill_tag;
            ent_d[fill_idx] = fill_ent;
        end
        if (flush) begin
            vld_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            tag_q[g] <= tag_d[g];
            ent_q[g] <= ent_d[g];
        end
    end

    assign hit     = vld_q[look_idx] && (tag_q[look_idx] == look_tag);
    assign hit_ent = ent_q[look_idx];
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm (
    input  logic       ent_present,
    input  logic       ent_writable,
    input  logic       ent_user,
    input  logic       acc_write,
    input  logic       acc_user,
    input  logic       wp_on,
    output logic       fault,
    output logic [2:0] code
);
    always_comb begin
        fault = !ent_present
             || (acc_user && !ent_user)
             || (acc_write && wp_on && !ent_writable);
        code  = fault ? {acc_user, acc_write, ent_present} : 3'b000;
    end
endmodule

// File: rtl/ptw_merge.sv
module ptw_merge
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0] tbl_ent,
    input  logic [VA_W-1:0] dir_ent,
    output logic [VA_W-1:0] merged
);
    always_comb begin
        merged         = tbl_ent;
        merged[B_WR]   = tbl_ent[B_WR]  & dir_ent[B_WR];
        merged[B_USR]  = tbl_ent[B_USR] & dir_ent[B_USR];
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int CACHE_IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [31:0]     req_lin,
    input  logic            req_write,
    input  logic            req_user,
    input  logic            pg_en,
    input  logic            wp_en,
    input  logic [31:0]     dir_base,
    input  logic            flush,
    output logic            mem_req,
    output logic            mem_we,
    output logic [31:0]     mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic            mem_ack,
    input  logic [31:0]     mem_rdata,
    output logic            done,
    output logic [31:0]     res_phys,
    output logic            res_writable,
    output logic            res_user,
    output logic            fault,
    output logic [2:0]      fault_code
);
    localparam int DPAD = VA_W - DIR_W - $clog2(ENT_B);
    localparam int TPAD = VA_W - TBL_W - $clog2(ENT_B);

    typedef struct packed {
        walk_st_e        st;
        logic [VA_W-1:0] lin;
        logic            wr;
        logic            usr;
        logic            wp;
        logic [VA_W-1:0] base;
        logic [VA_W-1:0] pde;
        logic [VA_W-1:0] pte;
        logic [VA_W-1:0] wdata;
        walk_res_t       res;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic            c_hit;
    logic [VA_W-1:0] c_ent;
    logic            fill_en;
    logic [VA_W-1:0] merged;
    logic [VA_W-1:0] tbl_src;
    logic [VA_W-1:0] upd_now;
    logic [VA_W-1:0] eval_ent;
    logic            pf;
    logic [2:0]      pcode;
    logic            ctx_wr, ctx_usr, ctx_wp;
    logic [VA_W-1:0] ctx_lin;
    logic [VA_W-1:0] dir_addr, tbl_addr;
    walk_res_t       res_now;

    ptw_tcache #(.IDX_W(CACHE_IDX_W)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .look_vpn (req_lin[VA_W-1:OFS_W]),
        .hit      (c_hit),
        .hit_ent  (c_ent),
        .fill_en  (fill_en),
        .fill_vpn (r_q.lin[VA_W-1:OFS_W]),
        .fill_ent (merged)
    );

    ptw_merge u_merge (
        .tbl_ent (tbl_src),
        .dir_ent (r_q.pde),
        .merged  (merged)
    );

    ptw_perm u_perm (
        .ent_present  (eval_ent[B_PRES]),
        .ent_writable (eval_ent[B_WR]),
        .ent_user     (eval_ent[B_USR]),
        .acc_write    (ctx_wr),
        .acc_user     (ctx_usr),
        .wp_on        (ctx_wp),
        .fault        (pf),
        .code         (pcode)
    );

    // Request context: live inputs while idle, latched copy during a walk
    always_comb begin
        if (r_q.st == ST_IDLE) begin
            ctx_wr  = req_write;
            ctx_usr = req_user;
            ctx_wp  = wp_en;
            ctx_lin = req_lin;
        end else begin
            ctx_wr  = r_q.wr;
            ctx_usr = r_q.usr;
            ctx_wp  = r_q.wp;
            ctx_lin = r_q.lin;
        end
    end

    assign upd_now  = mem_rdata | (VA_W'(1) << B_ACC) | (r_q.wr ? (VA_W'(1) << B_DRT) : '0);
    assign tbl_src  = (r_q.st == ST_TBL_RD) ? upd_now : r_q.pte;
    assign dir_addr = r_q.base + {{DPAD{1'b0}}, r_q.lin[VA_W-1 -: DIR_W], 2'b00};
    assign tbl_addr = {r_q.pde[VA_W-1:OFS_W], {OFS_W{1'b0}}}
                    + {{TPAD{1'b0}}, r_q.lin[OFS_W +: TBL_W], 2'b00};

    always_comb begin
        res_now.fault  = pf;
        res_now.code   = pcode;
        res_now.phys   = pf ? '0 : {eval_ent[VA_W-1:OFS_W], ctx_lin[OFS_W-1:0]};
        res_now.wr_ok  = !pf && eval_ent[B_WR];
        res_now.usr_ok = !pf && eval_ent[B_USR];
    end

    always_comb begin
        r_d      = r_q;
        fill_en  = 1'b0;
        eval_ent = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                eval_ent = c_ent;
                if (req_valid) begin
                    r_d.lin  = req_lin;
                    r_d.wr   = req_write;
                    r_d.usr  = req_user;
                    r_d.wp   = wp_en;
                    r_d.base = dir_base;
                    if (!pg_en) begin
                        r_d.res = '{fault: 1'b0, code: 3'b000, phys: req_lin,
                                    wr_ok: 1'b1, usr_ok: 1'b1};
                        r_d.st  = ST_DONE;
                    end else if (c_hit) begin
                        r_d.res = res_now;
                        r_d.st  = ST_DONE;
                    end else begin
                        r_d.st  = ST_DIR_RD;
                    end
                end
            end
            ST_DIR_RD: begin
                eval_ent = mem_rdata;
                if (mem_ack) begin
                    r_d.pde = mem_rdata;
                    if (!mem_rdata[B_PRES]) begin
                        r_d.res = res_now;
                        r_d.st  = ST_DONE;
                    end else if (!mem_rdata[B_ACC]) begin
                        r_d.wdata = mem_rdata | (VA_W'(1) << B_ACC);
                        r_d.st    = ST_DIR_WB;
                    end else begin
                        r_d.st  = ST_TBL_RD;
                    end
                end
            end
            ST_DIR_WB: begin
                if (mem_ack) begin
                    r_d.st = ST_TBL_RD;
                end
            end
            ST_TBL_RD: begin
                if (!mem_rdata[B_PRES]) begin
                    eval_ent = mem_rdata;
                end else begin
                    eval_ent = merged;
                end
                if (mem_ack) begin
                    r_d.pte = upd_now;
                    if (!mem_rdata[B_PRES]) begin
                        r_d.res = res_now;
                        r_d.st  = ST_DONE;
                    end else if (upd_now != mem_rdata) begin
                        r_d.wdata = upd_now;
                        r_d.st    = ST_TBL_WB;
                    end else begin
                        fill_en = 1'b1;
                        r_d.res = res_now;
                        r_d.st  = ST_DONE;
                    end
                end
            end
            ST_TBL_WB: begin
                eval_ent = merged;
                if (mem_ack) begin
                    fill_en = 1'b1;
                    r_d.res = res_now;
                    r_d.st  = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready    = (r_q.st == ST_IDLE);
    assign mem_req      = (r_q.st == ST_DIR_RD) || (r_q.st == ST_DIR_WB)
                       || (r_q.st == ST_TBL_RD) || (r_q.st == ST_TBL_WB);
    assign mem_we       = (r_q.st == ST_DIR_WB) || (r_q.st == ST_TBL_WB);
    assign mem_addr     = ((r_q.st == ST_DIR_RD) || (r_q.st == ST_DIR_WB)) ? dir_addr : tbl_addr;
    assign mem_wdata    = r_q.wdata;
    assign done         = (r_q.st == ST_DONE);
    assign res_phys     = r_q.res.phys;
    assign res_writable = r_q.res.wr_ok;
    assign res_user     = r_q.res.usr_ok;
    assign fault        = r_q.res.fault;
    assign fault_code   = r_q.res.code;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_lin,
    input logic        pg_en,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        done,
    input logic [31:0] res_phys,
    input logic        res_writable,
    input logic        res_user,
    input logic        fault,
    input logic [2:0]  fault_code
);
    logic        pg_q;
    logic [31:0] lin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q  <= 1'b0;
            lin_q <= '0;
        end else if (req_valid && req_ready) begin
            pg_q  <= pg_en;
            lin_q <= req_lin;
        end
    end

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    p_wb_accessed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[5] && mem_wdata[0]));

    p_nopg_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pg_q) |-> (res_phys == lin_q && !fault));

    p_clean_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (fault_code == 3'b000));

    p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (res_phys == 32'h0 && !res_writable && !res_user));

    p_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (res_phys[11:0] == lin_q[11:0]));
endmodule

bind pt_walker ptw_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_lin      (req_lin),
    .pg_en        (pg_en),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .done         (done),
    .res_phys     (res_phys),
    .res_writable (res_writable),
    .res_user     (res_user),
    .fault        (fault),
    .fault_code   (fault_code)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
    localparam logic [31:0] CR3 = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        pg_en = 1'b0;
    logic        wp_en = 1'b0;
    logic [31:0] dir_base = CR3;
    logic        flush = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] res_phys;
    logic        res_writable, res_user, fault;
    logic [2:0]  fault_code;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] mem [logic [31:0]];
    int          n_acc, n_wr;
    logic [31:0] acc_log [8];

    logic        c_v [16];
    logic [15:0] c_tag [16];
    logic [31:0] c_ent [16];

    always #2.5 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_lin(req_lin), .req_write(req_write), .req_user(req_user),
        .pg_en(pg_en), .wp_en(wp_en), .dir_base(dir_base), .flush(flush),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .res_phys(res_phys), .res_writable(res_writable),
        .res_user(res_user), .fault(fault), .fault_code(fault_code)
    );

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    function automatic logic [31:0] mk(input logic [19:0] fr, input logic p, w, u, a, d);
        return {fr, 5'b0, d, a, 2'b0, u, w, p};
    endfunction

    // memory responder: random ack delay, data presented away from the edge
    always @(negedge clk) begin
        mem_ack   <= mem_req && ($urandom_range(0, 3) != 0);
        mem_rdata <= mem_req ? rd(mem_addr) : 32'h0;
    end

    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            if (n_acc < 8) acc_log[n_acc] = mem_addr;
            n_acc = n_acc + 1;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                n_wr = n_wr + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 16; i++) c_v[i] = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] lin, input logic wr, input logic usr,
                          input logic pg, input logic wp, input string tag);
        logic [31:0] pa, ta, pde, pte, upd, comb, ent;
        logic [31:0] e_phys, e_pde, e_pte;
        logic        e_fault, e_w, e_u, walked, tbl_ok;
        logic [2:0]  e_code;
        int          e_acc, e_wr, cyc, t_pos;
        bit          busy_ok;
        logic [3:0]  ci;
        pa = CR3 + {20'b0, lin[31:22], 2'b00};
        ta = 32'h0; pde = 32'h0; pte = 32'h0; upd = 32'h0; ent = 32'h0;
        e_pde = 32'h0; e_pte = 32'h0;
        e_acc = 0; e_wr = 0; walked = 1'b0; tbl_ok = 1'b0; t_pos = 1;
        ci = lin[15:12];
        if (!pg) begin
            ent = {lin[31:12], 12'h007};
        end else if (c_v[ci] && c_tag[ci] == lin[31:16]) begin
            ent = c_ent[ci];
        end else begin
            walked = 1'b1;
            pde = rd(pa);
            e_acc = 1;
            ent = pde;
            e_pde = pde;
            if (pde[0]) begin
                if (!pde[5]) begin
                    e_pde = pde | 32'h20;
                    e_acc++; e_wr++; t_pos = 2;
                end
                ta = {pde[31:12], 12'h0} + {20'b0, lin[21:12], 2'b00};
                pte = rd(ta);
                e_acc++;
                ent = pte;
                e_pte = pte;
                if (pte[0]) begin
                    tbl_ok = 1'b1;
                    upd = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
                    e_pte = upd;
                    if (upd != pte) begin e_acc++; e_wr++; end
                    comb = upd;
                    comb[1] = upd[1] & pde[1];
                    comb[2] = upd[2] & pde[2];
                    ent = comb;
                    c_v[ci] = 1'b1; c_tag[ci] = lin[31:16]; c_ent[ci] = comb;
                end
            end
        end
        e_fault = !ent[0] || (usr && !ent[2]) || (wr && wp && !ent[1]);
        e_code  = e_fault ? {usr, wr, ent[0]} : 3'b000;
        e_phys  = e_fault ? 32'h0 : (pg ? {ent[31:12], lin[11:0]} : lin);
        e_w     = !e_fault && ent[1];
        e_u     = !e_fault && ent[2];

        while (!req_ready) @(negedge clk);
        n_acc = 0; n_wr = 0;
        req_valid = 1'b1; req_lin = lin; req_write = wr; req_user = usr;
        pg_en = pg; wp_en = wp;
        @(negedge clk);
        req_valid = 1'b0;
        req_lin = $urandom; req_write = $urandom_range(0, 1);
        cyc = 0; busy_ok = 1'b1;
        while (!done && cyc < 1000) begin
            if (mem_req && req_ready) busy_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        chk(done, {"R13 done seen ", tag}, 32'(done), 32'h1);
        chk(busy_ok, {"R12 ready low while walking ", tag}, 32'(busy_ok), 32'h1);
        if (!pg) chk(cyc == 0, {"R2 one-cycle latency ", tag}, 32'(cyc), 32'h0);
        chk(fault == e_fault, {"R9 fault ", tag}, 32'(fault), 32'(e_fault));
        chk(fault_code == e_code, {"R9 code ", tag}, 32'(fault_code), 32'(e_code));
        chk(res_phys == e_phys, {"R8 phys ", tag}, res_phys, e_phys);
        chk({res_writable, res_user} == {e_w, e_u}, {"R8 rights ", tag},
            32'({res_writable, res_user}), 32'({e_w, e_u}));
        chk(n_acc == e_acc, {"R10 access count ", tag}, 32'(n_acc), 32'(e_acc));
        chk(n_wr == e_wr, {"R7 write count ", tag}, 32'(n_wr), 32'(e_wr));
        if (walked) begin
            chk(acc_log[0] == pa, {"R3 directory address ", tag}, acc_log[0], pa);
            chk(rd(pa) == e_pde, {"R5 directory word ", tag}, rd(pa), e_pde);
            if (pde[0]) begin
                chk(acc_log[t_pos] == ta, {"R3 table address ", tag}, acc_log[t_pos], ta);
                chk(rd(ta) == e_pte, {"R7 table word ", tag}, rd(ta), e_pte);
            end
        end
        if (tbl_ok && e_pte != pte)
            chk(acc_log[t_pos + 1] == ta, {"R7 write-back address ", tag}, acc_log[t_pos + 1], ta);
        @(negedge clk);
        chk(!done && req_ready, {"R13 single pulse ", tag}, 32'({done, req_ready}), 32'h1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) c_v[i] = 1'b0;
        // random directories 0..3 (3 not present), table rows 0..7
        for (int d = 0; d < 4; d++) begin
            mem[CR3 + 32'(d * 4)] = mk(20'h00200 + 20'(d), d != 3, 1'($urandom),
                                       1'($urandom), 1'($urandom), 1'b0);
            for (int t = 0; t < 8; t++) begin
                mem[32'h0020_0000 + 32'(d * 4096) + 32'(t * 4)] =
                    mk(20'($urandom), $urandom_range(0, 7) != 0, 1'($urandom),
                       1'($urandom), 1'($urandom), 1'($urandom));
            end
        end
        // directed: directory 9 with accessed clear, rows 0..3
        mem[CR3 + 32'd36] = mk(20'h00300, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        mem[32'h0030_0000] = mk(20'hABCDE, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        mem[32'h0030_0004] = mk(20'h11111, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        mem[32'h0030_0008] = mk(20'h22222, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        mem[32'h0030_000C] = mk(20'h33333, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);

        repeat (3) @(negedge clk);
        chk(!done && req_ready && !mem_req, "R1 reset state",
            32'({done, req_ready, mem_req}), 32'h2);
        rst_n = 1'b1;
        @(negedge clk);

        lookup(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 1'b1, "R2 paging off");
        lookup({10'd8, 10'd0, 12'h123}, 1'b0, 1'b1, 1'b1, 1'b1, "R4 dir absent");
        lookup({10'd9, 10'd0, 12'h456}, 1'b1, 1'b1, 1'b1, 1'b1, "R5 dir wb and dirty");
        lookup({10'd9, 10'd0, 12'h789}, 1'b1, 1'b1, 1'b1, 1'b1, "R10 repeat hit");
        do_flush();
        lookup({10'd9, 10'd0, 12'h789}, 1'b0, 1'b0, 1'b1, 1'b1, "R11 after flush");
        lookup({10'd9, 10'd1, 12'h010}, 1'b0, 1'b1, 1'b1, 1'b1, "R9 user on supervisor");
        lookup({10'd9, 10'd1, 12'h020}, 1'b0, 1'b0, 1'b1, 1'b1, "R9 supervisor ok");
        lookup({10'd9, 10'd2, 12'h030}, 1'b1, 1'b0, 1'b1, 1'b1, "R9 write protect");
        lookup({10'd9, 10'd2, 12'h040}, 1'b1, 1'b0, 1'b1, 1'b0, "R9 protect off");
        lookup({10'd9, 10'd3, 12'h050}, 1'b1, 1'b0, 1'b1, 1'b1, "R6 table absent");

        for (int k = 0; k < 200; k++) begin
            logic [9:0]  d;
            logic [9:0]  t;
            d = 10'($urandom_range(0, 4));
            t = 10'($urandom_range(0, 7));
            if ($urandom_range(0, 24) == 0) do_flush();
            lookup({d, t, 12'($urandom)}, 1'($urandom), 1'($urandom),
                   $urandom_range(0, 9) != 0, 1'($urandom), "random");
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule